// File: doc/BRIEF.md
# Pipelined CORDIC Sine/Cosine Generator

This block turns a stream of angles into matching cosine and sine values. It uses the rotation form of CORDIC, so the datapath needs only adders, subtractors, arithmetic shifts and one fixed arctangent constant per stage. The iteration is unrolled into a chain of stages with a register after each one. A new angle can enter on every clock, and each result leaves a fixed number of cycles later.

The angle is a signed binary fraction of a half turn, so all angle words together cover the whole circle. The two top bits pick a quarter turn. That quarter turn is applied by choosing which axis the start vector lies on. The remaining bits form a residual angle, and the stage chain resolves it. The start vector already has the length of the inverse CORDIC gain. Because of this, no multiplier is needed anywhere, not even at the output.

A valid flag travels beside each sample. A synchronous active-low reset clears only these flags. Data registers are never reset and load only when their sample is valid.

Top module: `cordic_sincos`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` is low after that edge. Any sample that was in the pipeline, or that was presented during reset, never appears at the output.
- R2: A sample accepted at a rising edge (`in_valid` high) shows up with `out_valid` high exactly 32 rising edges later. `out_valid` is low one cycle before and one cycle after.
- R3: Angles applied on consecutive cycles give results on consecutive cycles, in the same order.
- R4: `in_angle` is a two's complement value `a`. It stands for the angle pi*a/2^31, which covers [-pi, pi). Bits 31:30 select the quarter turn.
- R5: `out_cos` and `out_sin` are signed with 14 fraction bits, so 1.0 is 16384. Each output is within 3 LSB of 16384 times the true cosine or sine.
- R6: An angle of 0 (0x00000000) gives a cosine near 16384 and a sine near 0.
- R7: An angle of +pi/2 (0x40000000) gives a cosine near 0 and a sine near +16384. An angle of -pi/2 (0xC0000000) gives a sine near -16384.
- R8: An angle of pi/4 (0x20000000) gives a cosine and a sine both near 11585.
- R9: Angles in the second and third quarter turns, including -pi (0x80000000, cosine near -16384), give results with the correct signs and values.
- R10: For every valid output, cos^2 + sin^2 is within 2*16384*4 of 16384^2.
- R11: A cycle with `in_valid` low produces a cycle with `out_valid` low exactly 32 cycles later. The valid samples around it are unaffected.
- R12: No output ever goes beyond +/-(16384+4). The internal guard bits prevent any wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the valid flags |
| in_valid | input | 1 | Marks `in_angle` as a sample this cycle |
| in_angle | input | 32 | Signed angle, pi*a/2^31 radians |
| out_valid | output | 1 | Marks `out_cos`/`out_sin` as a result this cycle |
| out_cos | output | 16 | Cosine, signed, 16384 = 1.0 |
| out_sin | output | 16 | Sine, signed, 16384 = 1.0 |

## Verification
Every result is due exactly 32 rising edges after the edge that captured its angle. Nothing in the datapath stalls, so that distance never changes. The bench drives inputs at falling edges and samples at falling edges. It checks a single angle at the 31st, 32nd and 33rd falling edges after it was driven, to show that the flag rises only at 32. In streaming runs, the bench checks the output at falling edge t against the input it drove at falling edge t-32. This covers the expected valid flag, so bubbles are checked too. After a reset, it watches longer than one full latency to make sure no flushed sample appears.

// File: rtl/cordic_pkg.sv
// Package: cordic_pkg
// Elaboration-time constants for the CORDIC chain: per-stage arctangent
// angles in binary-angle units and the fixed-point inverse gain.
// Assumes the caller passes a positive word width below 63 bits.
package cordic_pkg;

    localparam real PI_R = 3.14159265358979323846;

    // Returns atan(2^-idx) in radians; series for idx >= 1, exact for idx 0.
    function automatic real atan_pow2(input int idx);
        real x;
        real term;
        real acc;
        x = 1.0;
        acc = 0.0;
        if (idx == 0) begin
            return PI_R / 4.0;
        end
        for (int k = 0; k < idx; k++) begin
            x = x / 2.0;
        end
        term = x;
        for (int n = 0; n < 40; n++) begin
            if ((n % 2) == 0) begin
                acc = acc + term / real'(2 * n + 1);
            end else begin
                acc = acc - term / real'(2 * n + 1);
            end
            term = term * x * x;
        end
        return acc;
    endfunction

    // Stage angle scaled so that 2^angle_w units make one full turn.
    function automatic longint stage_angle(input int idx, input int angle_w);
        real scale;
        scale = 1.0;
        for (int k = 0; k < angle_w; k++) begin
            scale = scale * 2.0;
        end
        scale = scale / (2.0 * PI_R);
        return longint'(atan_pow2(idx) * scale);
    endfunction

    // Product of cos(atan(2^-i)) over all stages, as a real.
    function automatic real inv_gain(input int stages);
        real k2;
        real p;
        real r;
        k2 = 1.0;
        p  = 1.0;
        for (int i = 0; i < stages; i++) begin
            k2 = k2 / (1.0 + p * p);
            p  = p / 2.0;
        end
        r = 1.0;
        for (int n = 0; n < 40; n++) begin
            r = 0.5 * (r + k2 / r);
        end
        return r;
    endfunction

    // Inverse gain in fixed point with frac_bits fraction bits.
    function automatic longint inv_gain_fixed(input int stages, input int frac_bits);
        real s;
        s = 1.0;
        for (int k = 0; k < frac_bits; k++) begin
            s = s * 2.0;
        end
        return longint'(inv_gain(stages) * s);
    endfunction

endpackage

// File: rtl/cordic_prerot.sv
// Module: cordic_prerot
// Quarter-turn pre-rotation. Bits [AW-1:AW-2] of the angle select the axis
// on which the gain-compensated start vector lies; the remaining bits form
// the residual angle in [0, pi/2) handed to stage 0. Purely combinational.
// Assumes IW leaves two integer bits (1.0 = 2^(IW-2)).
module cordic_prerot #(
    parameter int AW     = 32,
    parameter int IW     = 22,
    parameter int STAGES = 32
) (
    input  logic        [AW-1:0] angle,
    output logic signed [IW-1:0] x0,
    output logic signed [IW-1:0] y0,
    output logic signed [AW-1:0] z0
);

    localparam logic signed [IW-1:0] K_FIX =
        IW'(cordic_pkg::inv_gain_fixed(STAGES, IW - 2));

    // Choose start vector from the quarter turn and strip it from the angle.
    always_comb begin
        z0 = {2'b00, angle[AW-3:0]};
        case (angle[AW-1:AW-2])
            2'b00: begin x0 = K_FIX;  y0 = '0;     end
            2'b01: begin x0 = '0;     y0 = K_FIX;  end
            2'b10: begin x0 = -K_FIX; y0 = '0;     end
            default: begin x0 = '0;   y0 = -K_FIX; end
        endcase
    end

endmodule

// File: rtl/cordic_stage.sv
// Module: cordic_stage
// One registered rotation step with index IDX. The sign of the residual
// angle picks the direction; x and y are updated with shifted copies of
// each other and the stage constant is removed from the residual.
// Only the valid flag is reset; data loads only with a valid sample.
module cordic_stage #(
    parameter int IDX = 0,
    parameter int IW  = 22,
    parameter int AW  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    input  logic signed [AW-1:0] z_i,
    output logic                 valid_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [AW-1:0] z_o
);

    localparam logic signed [AW-1:0] BETA = AW'(cordic_pkg::stage_angle(IDX, AW));
    // Shifts past the word width only repeat the sign, so clamp them.
    localparam int SH = (IDX < IW) ? IDX : IW - 1;

    logic signed [IW-1:0] x_sh;
    logic signed [IW-1:0] y_sh;
    logic signed [IW-1:0] x_nx;
    logic signed [IW-1:0] y_nx;
    logic signed [AW-1:0] z_nx;

    // Compute the micro-rotation toward a zero residual.
    always_comb begin
        x_sh = x_i >>> SH;
        y_sh = y_i >>> SH;
        if (!z_i[AW-1]) begin
            x_nx = x_i - y_sh;
            y_nx = y_i + x_sh;
            z_nx = z_i - BETA;
        end else begin
            x_nx = x_i + y_sh;
            y_nx = y_i - x_sh;
            z_nx = z_i + BETA;
        end
    end

    // Valid flag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
        end else begin
            valid_o <= valid_i;
        end
    end

    // Data registers, loaded only for valid samples, never reset.
    always_ff @(posedge clk) begin
        if (valid_i) begin
            x_o <= x_nx;
            y_o <= y_nx;
            z_o <= z_nx;
        end
    end

endmodule

// File: rtl/cordic_round.sv
// Module: cordic_round
// Drops the guard bits of an internal value with round-half-up.
// Assumes IW > OW and that the value has headroom for the rounding add.
module cordic_round #(
    parameter int IW = 22,
    parameter int OW = 16
) (
    input  logic signed [IW-1:0] v,
    output logic signed [OW-1:0] q
);

    localparam int G = IW - OW;
    localparam logic signed [IW-1:0] HALF = IW'(longint'(1) << (G - 1));

    // Round to the nearest output step.
    always_comb begin
        q = OW'((v + HALF) >>> G);
    end

endmodule

// File: rtl/cordic_sincos.sv
// Module: cordic_sincos
// Top of the pipelined sine/cosine generator: pre-rotation, STAGES
// registered rotation stages, then rounding of x and y to the output width.
// Latency is STAGES cycles, throughput one sample per cycle.
// Assumes GUARD >= 2 and STAGES >= 2.
module cordic_sincos #(
    parameter int ANGLE_W = 32,
    parameter int OUT_W   = 16,
    parameter int GUARD   = 6,
    parameter int STAGES  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [ANGLE_W-1:0]      in_angle,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_cos,
    output logic signed [OUT_W-1:0] out_sin
);

    localparam int IW = OUT_W + GUARD;

    logic [STAGES:0]              v_pipe;
    logic [STAGES:0][IW-1:0]      x_pipe;
    logic [STAGES:0][IW-1:0]      y_pipe;
    logic [STAGES:0][ANGLE_W-1:0] z_pipe;

    assign v_pipe[0] = in_valid;

    cordic_prerot #(
        .AW     (ANGLE_W),
        .IW     (IW),
        .STAGES (STAGES)
    ) u_prerot (
        .angle (in_angle),
        .x0    (x_pipe[0]),
        .y0    (y_pipe[0]),
        .z0    (z_pipe[0])
    );

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        cordic_stage #(
            .IDX (i),
            .IW  (IW),
            .AW  (ANGLE_W)
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid_i (v_pipe[i]),
            .x_i     (x_pipe[i]),
            .y_i     (y_pipe[i]),
            .z_i     (z_pipe[i]),
            .valid_o (v_pipe[i+1]),
            .x_o     (x_pipe[i+1]),
            .y_o     (y_pipe[i+1]),
            .z_o     (z_pipe[i+1])
        );
    end

    cordic_round #(.IW(IW), .OW(OUT_W)) u_rnd_cos (
        .v (x_pipe[STAGES]),
        .q (out_cos)
    );

    cordic_round #(.IW(IW), .OW(OUT_W)) u_rnd_sin (
        .v (y_pipe[STAGES]),
        .q (out_sin)
    );

    assign out_valid = v_pipe[STAGES];

endmodule

// File: rtl/cordic_sincos_chk.sv
// Module: cordic_sincos_chk
// Property checker bound to cordic_sincos. It keeps its own record of
// input flags and angles over STAGES cycles and relates them to outputs.
module cordic_sincos_chk #(
    parameter int ANGLE_W = 32,
    parameter int OUT_W   = 16,
    parameter int STAGES  = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [ANGLE_W-1:0]        in_angle,
    input logic                      out_valid,
    input logic signed [OUT_W-1:0]   out_cos,
    input logic signed [OUT_W-1:0]   out_sin,
    input logic signed [ANGLE_W-1:0] z_final
);

    localparam longint ONE = longint'(1) << (OUT_W - 2);

    logic [STAGES-1:0]  vsr;
    logic [ANGLE_W-1:0] asr [STAGES];
    longint c_l;
    longint s_l;
    longint z_l;
    longint mag;

    // Shadow of the valid flags, cleared with the design.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsr <= '0;
        end else begin
            vsr <= {vsr[STAGES-2:0], in_valid};
        end
    end

    // Shadow of the angles, shifted every cycle.
    always_ff @(posedge clk) begin
        asr[0] <= in_angle;
        for (int k = 1; k < STAGES; k++) begin
            asr[k] <= asr[k-1];
        end
    end

    // Widened copies of the outputs for arithmetic checks.
    always_comb begin
        c_l = longint'(out_cos);
        s_l = longint'(out_sin);
        z_l = longint'(z_final);
        mag = c_l * c_l + s_l * s_l;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vsr[STAGES-1]);

    assert_residual_small_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (z_l <= 64 && z_l >= -64));

    assert_zero_angle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && asr[STAGES-1] == '0) |-> (c_l >= ONE - 4 && s_l <= 4 && s_l >= -4));

    assert_unit_radius_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mag <= ONE * ONE + 8 * ONE && mag >= ONE * ONE - 8 * ONE));

    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (c_l <= ONE + 4 && c_l >= -ONE - 4 && s_l <= ONE + 4 && s_l >= -ONE - 4));

endmodule

bind cordic_sincos cordic_sincos_chk #(
    .ANGLE_W (ANGLE_W),
    .OUT_W   (OUT_W),
    .STAGES  (STAGES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_angle  (in_angle),
    .out_valid (out_valid),
    .out_cos   (out_cos),
    .out_sin   (out_sin),
    .z_final   (z_pipe[STAGES])
);

// File: tb/cordic_sincos_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module cordic_sincos_bench;

    localparam int  CLK_PERIOD = 10;
    localparam int  LAT        = 32;
    localparam real ONE        = 16384.0;
    localparam real TOL        = 3.0;
    localparam real PI_B       = 3.14159265358979323846;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [31:0]        in_angle = '0;
    logic               out_valid;
    logic signed [15:0] out_cos;
    logic signed [15:0] out_sin;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [31:0] seed = 32'h1234_5678;

    cordic_sincos u_cordic_sincos (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_angle  (in_angle),
        .out_valid (out_valid),
        .out_cos   (out_cos),
        .out_sin   (out_sin)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic real rabs(input real v);
        return (v < 0.0) ? -v : v;
    endfunction

    function automatic real to_rad(input logic [31:0] a);
        return real'($signed(a)) * PI_B / 2147483648.0;
    endfunction

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: valid actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_val(input string req, input string what, input int act, input real exp);
        n_checks++;
        if (rabs(real'(act) - exp) > TOL) begin
            n_fail++;
            $display("FAIL %s: %s actual %0d expected %0.2f", req, what, act, exp);
        end
    endtask

    task automatic chk_result(input string req, input logic [31:0] a);
        chk_val(req, "cos", int'(out_cos), ONE * $cos(to_rad(a)));
        chk_val(req, "sin", int'(out_sin), ONE * $sin(to_rad(a)));
    endtask

    // R1: reset holds the output idle and swallows inputs given during reset.
    task automatic test_reset();
        bit quiet;
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_angle = '0;
        repeat (4) begin
            @(negedge clk);
            chk_bit("R1 during reset", out_valid, 1'b0);
        end
        rst_n = 1'b1;
        in_valid = 1'b0;
        quiet = 1'b1;
        for (int t = 0; t < LAT + 8; t++) begin
            @(negedge clk);
            if (out_valid !== 1'b0) quiet = 1'b0;
        end
        chk_bit("R1 nothing emerges after reset", quiet, 1'b1);
    endtask

    // R2 plus value check: one sample, flag must rise only at edge LAT.
    task automatic test_single(input logic [31:0] a, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_angle = a;
        @(negedge clk);
        in_valid = 1'b0;
        in_angle = next_rand();
        repeat (LAT - 2) @(posedge clk);
        @(negedge clk);
        chk_bit("R2 low one cycle early", out_valid, 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk_bit("R2 high at latency", out_valid, 1'b1);
        chk_result(req, a);
        @(negedge clk);
        chk_bit("R2 low one cycle late", out_valid, 1'b0);
    endtask

    // R3/R11: stream of random angles, optionally with bubbles.
    task automatic test_stream(input int n, input bit gaps, input string req);
        logic [31:0] ang [64];
        bit          vin [64];
        for (int t = 0; t < n + LAT; t++) begin
            @(negedge clk);
            if (t >= LAT) begin
                chk_bit(req, out_valid, vin[t-LAT]);
                if (vin[t-LAT]) chk_result({req, " R4"}, ang[t-LAT]);
            end
            if (t < n) begin
                vin[t] = gaps ? ((t % 3) != 1) : 1'b1;
                ang[t] = next_rand();
                in_valid = vin[t];
                in_angle = ang[t];
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    // R1: reset while samples are in flight discards all of them.
    task automatic test_flush();
        bit quiet;
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_angle = next_rand();
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        quiet = 1'b1;
        for (int t = 0; t < LAT + 8; t++) begin
            @(negedge clk);
            if (out_valid !== 1'b0) quiet = 1'b0;
        end
        chk_bit("R1 in-flight samples flushed", quiet, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        test_reset();
        test_single(32'h0000_0000, "R6 zero");
        test_single(32'h4000_0000, "R7 +pi/2");
        test_single(32'hC000_0000, "R7 -pi/2");
        test_single(32'h2000_0000, "R8 pi/4");
        test_single(32'h6000_0000, "R9 3pi/4");
        test_single(32'h8000_0000, "R9 -pi");
        test_single(32'hA000_0000, "R9 -3pi/4");
        test_single(32'hE000_0000, "R5 -pi/4");
        test_single(32'h1555_5555, "R5 pi/6");
        test_stream(48, 1'b0, "R3 back-to-back");
        test_stream(48, 1'b1, "R11 bubbles");
        test_flush();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule